// File: doc/BRIEF.md
# Radix-8 Recoded Pipelined Significand Multiplier

This block multiplies two unsigned operands of `W` bits (64 by default, the size of an extended-precision significand) into an exact `2W`-bit product. The multiplier operand is split into 3-bit groups. A carry ripples through the groups and recodes each one into a signed digit between -4 and +3. Each digit picks one multiple of the multiplicand: 0, x, 2x and 4x come from wiring shifts alone, and 3x comes from a single adder shared by every partial product. A negative multiple is the bitwise inverse of its positive form. The missing +1 is dropped into a spare bit of a carry-in vector that joins the reduction, so no partial product needs an adder of its own.

The unit is fully pipelined. It accepts a new operand pair on any clock and returns each result exactly three clocks after it went in. Its `out_valid` flag repeats the `in_valid` pattern with that delay. The pipeline never stalls, so the surrounding floating-point datapath sets its schedule by counting cycles.

Top module: `r8_mult`

## Requirements
- R1: For any operands, `out_prod` equals the exact unsigned product `in_a * in_b` over all `2W` bits.
- R2: Each 3-bit group of `in_b`, with the carry from the group below added, gives a value v from 0 to 8. When v is 4 or more, the digit is v-8 and a carry of 1 passes to the next group. Otherwise the digit is v and no carry passes. Every digit lies in -4..+3, and long runs of 110 and 111 groups still give the exact product.
- R3: The 3x multiple is formed once per operand pair by one adder as x + 2x, and is exact even when x is all ones (the result needs W+2 bits).
- R4: A negative digit uses the inverted positive multiple plus a carry-in of 1 at the digit's weight. A digit of zero is never negative.
- R5: When the recoding leaves a carry out of the top group, one extra +1x term at weight 8^G is added, G being the number of groups. The product remains exact, including for widths that are a multiple of 3.
- R6: A zero in either operand gives a zero product.
- R7: A multiplier with a single set bit at position k gives the multiplicand shifted left by k.
- R8: A new operand pair can be accepted on every clock, and back-to-back results are each correct.
- R9: `out_valid` is high in exactly those cycles that come three clocks after a cycle in which `in_valid` was high.
- R10: While `rst_n` is low, and after it rises until the first valid input has passed through, `out_valid` is low and `out_prod` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned, recoded in radix 8 |
| out_valid | output | 1 | Product valid, three cycles after in_valid |
| out_prod | output | 2W | Unsigned product |

## Verification
The bench drives multipliers made of repeating 110/111, 011 and 100 groups, together with all-ones operands. These keep the recoding carry live across every group and force the widest 3x value. A design that mishandled the carry or the 3x width would return products wrong in their high bits. A second instance with 9-bit operands hits the case where a carry leaves the top group; a design without the extra +1x term would give a product short by exactly x·2^9. Idle bubbles mixed with back-to-back inputs show whether `out_valid` is off by a cycle, and any such error mismatches the sampled product stream.

// File: rtl/r8_mult_pkg.sv
package r8_mult_pkg;
   // one recoded radix-8 digit: sign and magnitude 0..4
   typedef struct packed {
      logic       neg;
      logic [2:0] mag;
   } r8_digit_t;

   localparam logic [2:0] MAG_ZERO = 3'd0;
   localparam logic [2:0] MAG_ONE  = 3'd1;
   localparam logic [2:0] MAG_TWO  = 3'd2;
   localparam logic [2:0] MAG_THR  = 3'd3;
   localparam logic [2:0] MAG_FOUR = 3'd4;
endpackage

// File: rtl/r8_recoder.sv
module r8_recoder
   import r8_mult_pkg::*;
#(
   parameter int W = 64,
   localparam int G = (W + 2) / 3
) (
   input  logic [W-1:0]          mplr,
   output r8_digit_t [G-1:0]     digits,
   output logic                  top_carry
);
   localparam int PADW = 3 * G;

   logic [PADW-1:0] padded;
   assign padded = {{(PADW-W){1'b0}}, mplr};

   // carry ripples upward: raw group + carry -> 0..8, fold 4..8 to v-8
   always_comb begin
      logic       cy;
      logic [3:0] v;
      cy = 1'b0;
      for (int g = 0; g < G; g++) begin
         v = {1'b0, padded[3*g +: 3]} + {3'b000, cy};
         if (v >= 4'd4) begin
            digits[g].mag = 3'(4'd8 - v);
            digits[g].neg = (v != 4'd8);
            cy            = 1'b1;
         end else begin
            digits[g].mag = v[2:0];
            digits[g].neg = 1'b0;
            cy            = 1'b0;
         end
      end
      top_carry = cy;
   end
endmodule

// File: rtl/r8_ppgen.sv
module r8_ppgen
   import r8_mult_pkg::*;
#(
   parameter int W = 64,
   localparam int G = (W + 2) / 3,
   localparam int P = 2 * W
) (
   input  logic [W-1:0]      mcand,
   input  logic [W+1:0]      mcand_x3,
   input  r8_digit_t [G-1:0] digits,
   input  logic              top_carry,
   output logic [P-1:0]      sum_vec,
   output logic [P-1:0]      cry_vec
);
   localparam int XSH = 3 * G;

   // pick a multiple, invert for negative, fold carry-ins, compress 3:2
   always_comb begin
      logic [W+1:0] m;
      logic [P-1:0] term, cin, s, c, ns;
      s   = '0;
      c   = '0;
      cin = '0;
      for (int g = 0; g < G; g++) begin
         unique case (digits[g].mag)
            MAG_ONE:  m = {2'b00, mcand};
            MAG_TWO:  m = {1'b0, mcand, 1'b0};
            MAG_THR:  m = mcand_x3;
            MAG_FOUR: m = {mcand, 2'b00};
            default:  m = '0;
         endcase
         term = {{(P-W-2){1'b0}}, m};
         if (digits[g].neg) begin
            term = ~term;
            cin[3*g] = 1'b1;
         end
         term = term << (3*g);
         ns = s ^ c ^ term;
         c  = ((s & c) | (s & term) | (c & term)) << 1;
         s  = ns;
      end
      // carry-in bits for the negated terms
      ns = s ^ c ^ cin;
      c  = ((s & c) | (s & cin) | (c & cin)) << 1;
      s  = ns;
      // extra +1x when recoding carries out of the top group
      term = top_carry ? ({{(P-W){1'b0}}, mcand} << XSH) : '0;
      ns = s ^ c ^ term;
      c  = ((s & c) | (s & term) | (c & term)) << 1;
      s  = ns;
      sum_vec = s;
      cry_vec = c;
   end
endmodule

// File: rtl/r8_mult.sv
module r8_mult
   import r8_mult_pkg::*;
#(
   parameter int W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [W-1:0]    in_a,
   input  logic [W-1:0]    in_b,
   output logic            out_valid,
   output logic [2*W-1:0]  out_prod
);
   localparam int G = (W + 2) / 3;
   localparam int P = 2 * W;

   generate
      if (W < 4) begin : g_bad_width
         $error("r8_mult: W must be at least 4");
      end
   endgenerate

   // stage 1: recoding and the shared 3x adder
   r8_digit_t [G-1:0] dig_c, dig_q;
   logic              tc_c, tc_q;
   logic [W+1:0]      x3_c, x3_q;
   logic [W-1:0]      x_q;
   logic              v1, v2;

   r8_recoder #(.W(W)) u_rec (
      .mplr      (in_b),
      .digits    (dig_c),
      .top_carry (tc_c)
   );

   assign x3_c = {2'b00, in_a} + {1'b0, in_a, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         x_q   <= '0;
         x3_q  <= '0;
         dig_q <= '0;
         tc_q  <= 1'b0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            x_q   <= in_a;
            x3_q  <= x3_c;
            dig_q <= dig_c;
            tc_q  <= tc_c;
         end
      end
   end

   // stage 2: selection and carry-save reduction
   logic [P-1:0] s_c, c_c, s_q, c_q;

   r8_ppgen #(.W(W)) u_pp (
      .mcand     (x_q),
      .mcand_x3  (x3_q),
      .digits    (dig_q),
      .top_carry (tc_q),
      .sum_vec   (s_c),
      .cry_vec   (c_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2  <= 1'b0;
         s_q <= '0;
         c_q <= '0;
      end else begin
         v2 <= v1;
         if (v1) begin
            s_q <= s_c;
            c_q <= c_c;
         end
      end
   end

   // stage 3: final carry-propagate add
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_prod  <= '0;
      end else begin
         out_valid <= v2;
         if (v2) out_prod <= s_q + c_q;
      end
   end

   // checks on the pipeline and the recoded digits
   a_r9_enter_stage1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> v1);
   a_r9_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
      v1 |=> v2);
   a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      !v2 |=> !out_valid);
   a_r3_triple: assert property (@(posedge clk) disable iff (!rst_n)
      v1 |-> (x3_q == ({2'b00, x_q} + {2'b00, x_q} + {2'b00, x_q})));

   generate
      for (genvar g = 0; g < G; g++) begin : g_dig_chk
         a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            v1 |-> (dig_q[g].mag <= MAG_FOUR) && (dig_q[g].mag != MAG_FOUR || dig_q[g].neg));
         a_r4_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
            v1 && (dig_q[g].mag == MAG_ZERO) |-> !dig_q[g].neg);
      end
   endgenerate
endmodule

// File: tb/r8_mult_test.sv
module r8_mult_test;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 64;
   localparam int WS = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [W-1:0]    in_a = '0, in_b = '0;
   logic            out_valid, out_valid_s;
   logic [2*W-1:0]  out_prod;
   logic [2*WS-1:0] out_prod_s;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   r8_mult #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_prod(out_prod)
   );

   r8_mult #(.W(WS)) uut_s (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_a(in_a[WS-1:0]), .in_b(in_b[WS-1:0]),
      .out_valid(out_valid_s), .out_prod(out_prod_s)
   );

   typedef struct {
      bit           v;
      logic [W-1:0] a;
      logic [W-1:0] b;
      string        tag;
   } ent_t;

   ent_t pend[$];

   task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act,
                      input logic [2*W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare the outputs against the entry driven three cycles ago
   task automatic check_front();
      ent_t e;
      logic [2*W-1:0]  r;
      logic [2*WS-1:0] rs;
      e = pend.pop_front();
      chk(out_valid == e.v, "R9", {127'b0, out_valid}, {127'b0, e.v});
      chk(out_valid_s == e.v, "R9", {127'b0, out_valid_s}, {127'b0, e.v});
      if (e.v) begin
         r  = {{W{1'b0}}, e.a} * {{W{1'b0}}, e.b};
         rs = {{WS{1'b0}}, e.a[WS-1:0]} * {{WS{1'b0}}, e.b[WS-1:0]};
         chk(out_prod == r, e.tag, out_prod, r);
         chk(out_prod_s == rs, (e.tag == "R5") ? "R5" : e.tag,
             {{(2*W-2*WS){1'b0}}, out_prod_s}, {{(2*W-2*WS){1'b0}}, rs});
      end
   endtask

   task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
      ent_t e;
      @(negedge clk);
      check_front();
      in_valid = v;
      in_a = a;
      in_b = b;
      e.v = v; e.a = a; e.b = b; e.tag = tag;
      pend.push_back(e);
   endtask

   // multiplier built from alternating 3-bit groups lo,hi,lo,hi from the LSB
   function automatic logic [W-1:0] rep6(input int lo, input int hi);
      logic [W-1:0] r = '0;
      for (int k = 0; k < W; k += 3) begin
         r = r | (W'(((k / 3) % 2 == 0) ? lo : hi) << k);
      end
      return r;
   endfunction

   function automatic logic [W-1:0] rnd();
      return {$urandom, $urandom};
   endfunction

   initial begin
      ent_t idle;
      idle.v = 0; idle.a = '0; idle.b = '0; idle.tag = "";
      for (int i = 0; i < 3; i++) pend.push_back(idle);
      // R10: outputs quiet in reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0 && out_prod == '0, "R10", out_prod, '0);
         chk(out_valid_s == 1'b0 && out_prod_s == '0, "R10",
             {{(2*W-2*WS){1'b0}}, out_prod_s}, '0);
      end
      rst_n = 1'b1;
      step(0, '0, '0, "");
      @(negedge clk);
      chk(out_valid == 1'b0 && out_prod == '0, "R10", out_prod, '0);
      // R6: zero operands
      step(1, '0, rnd(), "R6");
      step(1, rnd(), '0, "R6");
      step(1, '0, '0, "R6");
      // R7: single set bit multipliers
      for (int k = 0; k < W; k += 7) step(1, rnd(), W'(1) << k, "R7");
      step(1, rnd(), W'(1) << (W-1), "R7");
      // R2: long recoding carry chains
      step(1, '1, '1, "R2");
      step(1, rnd(), rep6(7, 6), "R2");
      step(1, '1, rep6(6, 7), "R2");
      step(1, rnd(), rep6(7, 7), "R2");
      // R3: 3x multiples, widest when x is all ones
      step(1, '1, rep6(3, 3), "R3");
      step(1, rnd(), rep6(3, 3), "R3");
      // R4: negative digits
      step(1, rnd(), rep6(4, 4), "R4");
      step(1, '1, rep6(5, 4), "R4");
      step(1, rnd(), rep6(6, 5), "R4");
      // R5: carry out of the top group on the narrow instance
      step(1, rnd(), W'('h1FF), "R5");
      step(1, W'('h1FF), W'('h1C0), "R5");
      step(1, rnd(), W'('h0E0), "R5");
      step(1, W'('h1FF), W'('h120), "R5");
      // R9: bubbles between inputs
      for (int i = 0; i < 12; i++) begin
         step(i % 3 == 0, rnd(), rnd(), "R9");
         step(0, rnd(), rnd(), "R9");
      end
      // R8 and R1: back-to-back random stream
      for (int i = 0; i < 300; i++) step(1, rnd(), rnd(), (i % 2) ? "R8" : "R1");
      for (int i = 0; i < 4; i++) step(0, '0, '0, "");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule